// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two external-memory strobes of a processor core that runs a machine cycle of twelve oscillator clocks: an active-high address latch strobe and an active-low code fetch strobe. It runs on the oscillator clock. From its own phase counter it places two latch pulses and two fetch pulses in every machine cycle. The pulses are shaped by the bus state the core reports: whether code runs from external memory, whether an external data transfer is under way, whether a code-table read is under way, and a control bit that suppresses the latch strobe.

The bus state inputs are sampled once per machine cycle, on the clock edge at which the phase wraps to zero. They then govern the whole cycle, so a change in the middle of a cycle cannot cut a strobe short. Both strobes are registered outputs. They are decoded from the next phase value and the next sampled state, so they carry no decode glitches. The current phase is also brought out for other cycle-aligned logic.

Top module: `bus_strobe_gen`

## Requirements
- R1: While rst_ni is low, phase_o is 11, ale_o is 0 and psen_no is 1.
- R2: After reset, phase_o advances by one on every clock, from 11 to 0 and then through 1..11, and repeats.
- R3: The four bus state inputs are taken only on the edge at which phase_o goes from 11 to 0. A change at any other time has no effect on ale_o or psen_no until the next cycle starts.
- R4: In a cycle sampled with no data transfer and no forced-high condition, ale_o is 1 at phases 0, 1, 6 and 7 and 0 at all other phases.
- R5: In a cycle sampled with movx_i=1 and no forced-high condition, the phase 0-1 latch pulse is dropped (ale_o is 0 there), and the phase 6-7 pulse still appears.
- R6: In a cycle sampled with ale_off_i=1, ext_exec_i=0, movx_i=0 and movc_i=0, ale_o is 1 at every phase.
- R7: With ale_off_i=1, a cycle sampled with movx_i=1 or movc_i=1 produces latch pulses as in R4 and R5.
- R8: With ext_exec_i=1 sampled, ale_off_i has no effect, and ale_o follows R4 and R5.
- R9: In a cycle sampled with ext_exec_i=1 and movx_i=0, psen_no is 0 at phases 3, 4, 5, 9, 10 and 11 and 1 at the other phases.
- R10: In a cycle sampled with ext_exec_i=1 and movx_i=1, psen_no is 1 for the whole cycle.
- R11: In a cycle sampled with ext_exec_i=0, psen_no is 1 for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_exec_i | input | 1 | Core executes from external code memory |
| movx_i | input | 1 | External data transfer in this machine cycle |
| movc_i | input | 1 | Code-table read in this machine cycle |
| ale_off_i | input | 1 | Suppress the latch strobe outside table and data accesses |
| phase_o | output | 4 | Oscillator-clock phase within the machine cycle, 0..11 |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | Code fetch strobe, active low |

## Verification
The bench builds the block with its defaults: a twelve-clock cycle, two strobe slots per cycle, a two-clock latch pulse, a three-clock fetch pulse starting three clocks into each slot, and the first latch pulse as the one dropped on data transfers. With these values both slots, the phase 11 to 0 wrap and the fetch pulse that ends on the last phase all recur every twelve clocks. Every combination of the four state bits can therefore be reached in a few cycles. Mid-cycle input changes test that sampling happens only at the wrap.

// File: rtl/bstrb_pkg.sv
package bstrb_pkg;

  typedef struct packed {
    logic ext;
    logic movx;
    logic movc;
    logic ale_off;
  } bus_state_t;

endpackage

// File: rtl/bstrb_phase_ctr.sv
module bstrb_phase_ctr #(
  parameter int CYCLE_CLKS = 12,
  localparam int PH_W = $clog2(CYCLE_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic [PH_W-1:0] phase_nxt_o,
  output logic            wrap_o
);

  localparam logic [PH_W-1:0] LAST = PH_W'(CYCLE_CLKS - 1);

  logic [PH_W-1:0] phase_q;

  assign wrap_o      = (phase_q == LAST);
  assign phase_nxt_o = wrap_o ? '0 : phase_q + 1'b1;
  assign phase_o     = phase_q;

  // reset parks on the last phase so the first edge opens a fresh cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= LAST;
    else         phase_q <= phase_nxt_o;
  end

endmodule

// File: rtl/bstrb_ale_gen.sv
module bstrb_ale_gen
  import bstrb_pkg::*;
#(
  parameter int CYCLE_CLKS = 12,
  parameter int PULSES     = 2,
  parameter int ALE_W      = 2,
  parameter int SKIP_IDX   = 0,
  localparam int PH_W = $clog2(CYCLE_CLKS)
) (
  input  logic [PH_W-1:0] phase_i,
  input  bus_state_t      st_i,
  output logic            ale_o
);

  localparam int SLOT = CYCLE_CLKS / PULSES;

  logic [PULSES-1:0] hit;
  logic [PULSES-1:0] keep;
  logic              forced_hi;

  for (genvar i = 0; i < PULSES; i++) begin : g_slot
    localparam logic [PH_W-1:0] LO = PH_W'(i * SLOT);
    logic [PH_W-1:0] off;
    assign off     = phase_i - LO;
    assign hit[i]  = (phase_i >= LO) && (off < PH_W'(ALE_W));
    if (i == SKIP_IDX) begin : g_skip
      assign keep[i] = !st_i.movx;
    end else begin : g_keep
      assign keep[i] = 1'b1;
    end
  end

  // suppression only applies on internal execution with no table/data access
  assign forced_hi = st_i.ale_off && !st_i.ext && !st_i.movx && !st_i.movc;
  assign ale_o     = forced_hi | (|(hit & keep));

endmodule

// File: rtl/bstrb_psen_gen.sv
module bstrb_psen_gen #(
  parameter int CYCLE_CLKS = 12,
  parameter int PULSES     = 2,
  parameter int PSEN_OFS   = 3,
  parameter int PSEN_W     = 3,
  localparam int PH_W = $clog2(CYCLE_CLKS)
) (
  input  logic [PH_W-1:0] phase_i,
  input  logic            ext_i,
  input  logic            movx_i,
  output logic            psen_no
);

  localparam int SLOT = CYCLE_CLKS / PULSES;

  logic [PULSES-1:0] hit;

  for (genvar i = 0; i < PULSES; i++) begin : g_slot
    localparam logic [PH_W-1:0] LO = PH_W'(i * SLOT + PSEN_OFS);
    logic [PH_W-1:0] off;
    assign off    = phase_i - LO;
    assign hit[i] = (phase_i >= LO) && (off < PH_W'(PSEN_W));
  end

  assign psen_no = !(ext_i && !movx_i && (|hit));

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bstrb_pkg::*;
#(
  parameter int CYCLE_CLKS = 12,
  parameter int PULSES     = 2,
  parameter int ALE_W      = 2,
  parameter int PSEN_OFS   = 3,
  parameter int PSEN_W     = 3,
  parameter int SKIP_IDX   = 0,
  localparam int PH_W = $clog2(CYCLE_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_exec_i,
  input  logic            movx_i,
  input  logic            movc_i,
  input  logic            ale_off_i,
  output logic [PH_W-1:0] phase_o,
  output logic            ale_o,
  output logic            psen_no
);

  logic [PH_W-1:0] phase_nxt;
  logic            wrap;
  bus_state_t      st_q, st_d, st_in;
  logic            ale_d, psen_nd;
  logic            ale_q, psen_nq;

  bstrb_phase_ctr #(.CYCLE_CLKS(CYCLE_CLKS)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_o     (phase_o),
    .phase_nxt_o (phase_nxt),
    .wrap_o      (wrap)
  );

  assign st_in = '{ext: ext_exec_i, movx: movx_i, movc: movc_i, ale_off: ale_off_i};
  assign st_d  = wrap ? st_in : st_q;

  // strobes decoded one step ahead and registered: glitch-free outputs
  bstrb_ale_gen #(
    .CYCLE_CLKS (CYCLE_CLKS),
    .PULSES     (PULSES),
    .ALE_W      (ALE_W),
    .SKIP_IDX   (SKIP_IDX)
  ) u_ale (
    .phase_i (phase_nxt),
    .st_i    (st_d),
    .ale_o   (ale_d)
  );

  bstrb_psen_gen #(
    .CYCLE_CLKS (CYCLE_CLKS),
    .PULSES     (PULSES),
    .PSEN_OFS   (PSEN_OFS),
    .PSEN_W     (PSEN_W)
  ) u_psen (
    .phase_i (phase_nxt),
    .ext_i   (st_d.ext),
    .movx_i  (st_d.movx),
    .psen_no (psen_nd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      ale_q   <= 1'b0;
      psen_nq <= 1'b1;
    end else begin
      st_q    <= st_d;
      ale_q   <= ale_d;
      psen_nq <= psen_nd;
    end
  end

  assign ale_o   = ale_q;
  assign psen_no = psen_nq;

endmodule

// File: rtl/bstrb_checker.sv
module bstrb_checker #(
  parameter int CYCLE_CLKS = 12,
  localparam int PH_W = $clog2(CYCLE_CLKS)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ext_exec_i,
  input logic            movx_i,
  input logic            movc_i,
  input logic            ale_off_i,
  input logic [PH_W-1:0] phase_o,
  input logic            ale_o,
  input logic            psen_no
);

  localparam logic [PH_W-1:0] LAST = PH_W'(CYCLE_CLKS - 1);

  logic ext_c, mx_c, mc_c, off_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_c <= 1'b0; mx_c <= 1'b0; mc_c <= 1'b0; off_c <= 1'b0;
    end else if (phase_o == LAST) begin
      ext_c <= ext_exec_i; mx_c <= movx_i; mc_c <= movc_i; off_c <= ale_off_i;
    end
  end

  a_r2_phase_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == LAST |=> phase_o == '0);

  a_r2_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != LAST |=> phase_o == $past(phase_o) + 1'b1);

  a_r5_movx_drops_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mx_c && phase_o == '0) |-> !ale_o);

  a_r6_forced_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_c && !ext_c && !mx_c && !mc_c) |-> ale_o);

  a_r9_psen_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psen_no) |=> !psen_no);

  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && !psen_no));

  a_r10_movx_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mx_c |-> psen_no);

  a_r11_internal_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_c |-> psen_no);

endmodule

bind bus_strobe_gen bstrb_checker #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_exec_i (ext_exec_i),
  .movx_i     (movx_i),
  .movc_i     (movc_i),
  .ale_off_i  (ale_off_i),
  .phase_o    (phase_o),
  .ale_o      (ale_o),
  .psen_no    (psen_no)
);

// File: tb/sim_bus_strobe_gen.sv
`timescale 1ns/1ps
module sim_bus_strobe_gen;

  localparam int LAST = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext = 1'b0, mx = 1'b0, mc = 1'b0, off = 1'b0;
  logic [3:0] ph;
  logic       ale, psen_n;

  always #2.5 clk = ~clk;

  bus_strobe_gen u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ext_exec_i (ext),
    .movx_i     (mx),
    .movc_i     (mc),
    .ale_off_i  (off),
    .phase_o    (ph),
    .ale_o      (ale),
    .psen_no    (psen_n)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  int  m_ph = LAST;
  bit  c_ext = 0, c_mx = 0, c_mc = 0, c_off = 0;

  function automatic bit exp_ale(int p, bit e, bit x, bit c, bit o);
    if (o && !e && !x && !c) return 1'b1;
    if (p == 0 || p == 1) return !x;
    if (p == 6 || p == 7) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_psen_n(int p, bit e, bit x);
    if (e && !x && ((p >= 3 && p <= 5) || (p >= 9 && p <= 11))) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string ale_req();
    if ({ext, mx, mc, off} != {c_ext, c_mx, c_mc, c_off}) return "R3";
    if (c_off && !c_ext && !c_mx && !c_mc) return "R6";
    if (c_off && c_ext) return "R8";
    if (c_off) return "R7";
    if (c_mx) return "R5";
    return "R4";
  endfunction

  function automatic string psen_req();
    if ({ext, mx} != {c_ext, c_mx}) return "R3";
    if (!c_ext) return "R11";
    if (c_mx) return "R10";
    return "R9";
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // one clock: model follows the edge using the inputs the design saw
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (m_ph == LAST) begin
      m_ph = 0;
      c_ext = ext; c_mx = mx; c_mc = mc; c_off = off;
    end else begin
      m_ph++;
    end
    chk("R2", "phase", int'(ph), m_ph);
    chk(ale_req(), "ale", int'(ale), int'(exp_ale(m_ph, c_ext, c_mx, c_mc, c_off)));
    chk(psen_req(), "psen_n", int'(psen_n), int'(exp_psen_n(m_ph, c_ext, c_mx)));
  endtask

  task automatic run(int ncyc, bit e, bit x, bit c, bit o, bit jit);
    for (int k = 0; k < ncyc * 12; k++) begin
      if (jit && (m_ph != LAST) && ($urandom % 3 == 0)) begin
        {ext, mx, mc, off} = 4'($urandom);
      end else begin
        {ext, mx, mc, off} = {e, x, c, o};
      end
      step();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #12;
    // R1: reset state
    chk("R1", "phase", int'(ph), LAST);
    chk("R1", "ale", int'(ale), 0);
    chk("R1", "psen_n", int'(psen_n), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: every relevant state combination, whole cycles
    run(2, 0, 0, 0, 0, 0);   // R4, R11
    run(2, 0, 1, 0, 0, 0);   // R5
    run(2, 0, 0, 0, 1, 0);   // R6
    run(2, 0, 1, 0, 1, 0);   // R7 via movx
    run(2, 0, 0, 1, 1, 0);   // R7 via movc
    run(2, 1, 0, 0, 0, 0);   // R9
    run(2, 1, 1, 0, 0, 0);   // R10
    run(2, 1, 0, 0, 1, 0);   // R8
    run(2, 1, 1, 0, 1, 0);   // R8 with R5
    // R3: mid-cycle toggling around fixed wrap-time values
    run(3, 1, 0, 0, 0, 1);
    run(3, 0, 0, 0, 1, 1);

    // constrained random: per-cycle state, sometimes jittered
    for (int n = 0; n < 300; n++) begin
      logic [3:0] s;
      s = 4'($urandom);
      run(1, s[3], s[2], s[1], s[0], ($urandom % 3) == 0);
    end

    // R1 again: reset in the middle of a cycle
    run(1, 1, 0, 0, 0, 0);
    repeat (4) step();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "phase", int'(ph), LAST);
    chk("R1", "ale", int'(ale), 0);
    chk("R1", "psen_n", int'(psen_n), 1);
    {ext, mx, mc, off} = 4'b0;
    m_ph = LAST; c_ext = 0; c_mx = 0; c_mc = 0; c_off = 0;
    @(negedge clk);
    rst_n = 1'b1;
    run(2, 0, 0, 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule